// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 32-bit physical address by reading a two-level page table from memory. A request carries the virtual address, a write flag, a user-mode flag and the frame number of the directory page. The walker reads the directory entry and, for a normal 4 KB mapping, the table entry. It then returns the physical address and the low twelve flag bits of the final entry, or a fault with a cause code.

The directory index is virtual address bits 31..22, the table index is bits 21..12, and the page offset is bits 11..0. Entries are 32-bit words. Bits 31..12 of an entry give the frame of the next table or of the mapped page.

The entry flag bits the walker decodes are: bit 0 present, bit 1 writable, bit 2 user allowed, and bit 7 large page (directory level only). A directory entry with bit 7 set maps a 4 MB page directly. Permission is checked during the walk. A supervisor access never raises a protection fault. Translations are not cached, and accessed or dirty bits are never written back.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` and `mem_req_o` are 0.
- R2: The first read of a walk is at address {`req_root_i`, va[31:22], 2'b00}. The second read is at {directory entry[31:12], va[21:12], 2'b00}.
- R3: For a present directory entry with bit 7 clear, followed by a present table entry with access allowed, the response has `rsp_fault_o`=0 and `rsp_cause_o`=0. The physical address is {table entry[31:12], va[11:0]} and the flags are table entry[11:0]. The walk makes exactly two reads.
- R4: A present directory entry with bit 7 set ends the walk after one read. With access allowed, the physical address is {directory entry[31:22], va[21:0]} and the flags are directory entry[11:0].
- R5: A directory or table entry with bit 0 clear ends the walk at that level with `rsp_fault_o`=1 and `rsp_cause_o`=1 (not present), and the flags are that entry's [11:0]. The present bit is tested before the large-page bit.
- R6: A user access (`req_user_i`=1) faults with `rsp_cause_o`=2 (protection) when bit 2 is 0 in any entry on the walk path.
- R7: A user write faults with cause 2 when bit 1 is 0 in any entry on the walk path. A user read of such a page succeeds.
- R8: A supervisor access (`req_user_i`=0) never produces cause 2. A supervisor write to a read-only or supervisor-only page succeeds.
- R9: When a non-large directory entry alone denies a user access (bit 2 clear, or bit 1 clear on a write), the walk ends with cause 2 after one read. The flags are the directory entry's.
- R10: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_gnt_i`. The walker never has more than one read outstanding. `req_ready_o` is 1 only while idle. `rsp_valid_o` is a single-cycle pulse.
- R11: Flag bits 3..6 and 8..11, and bit 7 of a table entry, do not affect the outcome. They are returned unchanged in `rsp_flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is made in user mode |
| req_root_i | input | 20 | Frame number of the directory page |
| mem_req_o | output | 1 | Memory read request |
| mem_gnt_i | input | 1 | Memory accepts the read request |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| rsp_valid_o | output | 1 | Response valid for one cycle |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_cause_o | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_paddr_o | output | 32 | Translated physical address (valid when no fault) |
| rsp_flags_o | output | 12 | Low flag bits of the final or faulting entry |

## Verification
The bench targets several corner cases:

- **Supervisor writes to read-only pages.** A design that enforced bit 1 in supervisor mode would fault these writes.
- **Permission split across levels.** The directory entry is read-only and the table entry writable, or the reverse. A design that took permissions from only one level would let a user write through.
- **Large-page offsets.** Offsets with high table-index bits set would expose a large-page address that wrongly kept table-entry bits.
- **Bit-order corner cases.** A not-present directory entry has bit 7 set, and a table entry has bit 7 set. These catch a walker that tests the large-page bit before the present bit, or one that decodes bit 7 at the second level.

Read counts and read addresses are compared on every walk, including one with a non-zero directory frame. This exposes early-abort and address-formation errors. A reset in mid-walk must return the walker to idle with no read pending.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W   = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int FRAME_W  = ADDR_W - OFF_W;
  localparam int LG_OFF_W = OFF_W + IDX_W;
  localparam int ENT_SH   = OFF_W - IDX_W;  // log2 of entry size in bytes
  localparam int FLAG_W   = OFF_W;

  localparam int FB_P  = 0;
  localparam int FB_RW = 1;
  localparam int FB_US = 2;
  localparam int FB_PS = 7;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_NP   = 2'd1,
    CAUSE_PROT = 2'd2
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PDE,
    ST_PTE,
    ST_DONE,
    ST_FAULT
  } state_e;
endpackage

// File: rtl/ptw_check.sv
module ptw_check
  import ptw_pkg::*;
(
  input  logic   [2:0] flags_i,   // {user, writable, present}
  input  logic         up_us_i,
  input  logic         up_rw_i,
  input  logic         user_i,
  input  logic         write_i,
  output logic         us_eff_o,
  output logic         rw_eff_o,
  output cause_e       cause_o
);
  always_comb begin
    us_eff_o = flags_i[FB_US] & up_us_i;
    rw_eff_o = flags_i[FB_RW] & up_rw_i;
    if (!flags_i[FB_P])
      cause_o = CAUSE_NP;
    else if (user_i && (!us_eff_o || (write_i && !rw_eff_o)))
      cause_o = CAUSE_PROT;
    else
      cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
(
  input  logic [FRAME_W-1:0] root_i,
  input  logic [ADDR_W-1:0]  va_i,
  input  logic [FRAME_W-1:0] pde_frame_i,
  input  logic [FRAME_W-1:0] pte_frame_i,
  input  logic               sel_pte_i,
  input  logic               large_i,
  output logic [ADDR_W-1:0]  ent_addr_o,
  output logic [ADDR_W-1:0]  paddr_o
);
  always_comb begin
    if (sel_pte_i)
      ent_addr_o = {pde_frame_i, va_i[LG_OFF_W-1:OFF_W], {ENT_SH{1'b0}}};
    else
      ent_addr_o = {root_i, va_i[ADDR_W-1:LG_OFF_W], {ENT_SH{1'b0}}};
    if (large_i)
      paddr_o = {pde_frame_i[FRAME_W-1:IDX_W], va_i[LG_OFF_W-1:0]};
    else
      paddr_o = {pte_frame_i, va_i[OFF_W-1:0]};
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_vaddr_i,
  input  logic               req_write_i,
  input  logic               req_user_i,
  input  logic [FRAME_W-1:0] req_root_i,
  output logic               mem_req_o,
  input  logic               mem_gnt_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ADDR_W-1:0]  mem_rdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_fault_o,
  output logic [1:0]         rsp_cause_o,
  output logic [ADDR_W-1:0]  rsp_paddr_o,
  output logic [FLAG_W-1:0]  rsp_flags_o
);
  state_e             state_q;
  logic               issued_q;
  logic [ADDR_W-1:0]  va_q;
  logic               wr_q, usr_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] pde_frame_q;
  logic               pde_us_q, pde_rw_q;
  logic [ADDR_W-1:0]  ent_q;
  logic               large_q;
  cause_e             cause_q;

  logic   at_pte, rd_done, us_eff, rw_eff;
  cause_e chk_cause;

  assign at_pte  = (state_q == ST_PTE);
  assign rd_done = issued_q && mem_rvalid_i;

  // Same checker serves both levels; directory level inherits full rights.
  ptw_check u_check (
    .flags_i  (mem_rdata_i[2:0]),
    .up_us_i  (at_pte ? pde_us_q : 1'b1),
    .up_rw_i  (at_pte ? pde_rw_q : 1'b1),
    .user_i   (usr_q),
    .write_i  (wr_q),
    .us_eff_o (us_eff),
    .rw_eff_o (rw_eff),
    .cause_o  (chk_cause)
  );

  ptw_addr u_addr (
    .root_i      (root_q),
    .va_i        (va_q),
    .pde_frame_i (pde_frame_q),
    .pte_frame_i (ent_q[ADDR_W-1:OFF_W]),
    .sel_pte_i   (at_pte),
    .large_i     (large_q),
    .ent_addr_o  (mem_addr_o),
    .paddr_o     (rsp_paddr_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_PDE || state_q == ST_PTE) && !issued_q;
  assign rsp_valid_o = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault_o = (state_q == ST_FAULT);
  assign rsp_cause_o = cause_q;
  assign rsp_flags_o = ent_q[FLAG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      issued_q    <= 1'b0;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      root_q      <= '0;
      pde_frame_q <= '0;
      pde_us_q    <= 1'b0;
      pde_rw_q    <= 1'b0;
      ent_q       <= '0;
      large_q     <= 1'b0;
      cause_q     <= CAUSE_NONE;
    end else begin
      if (mem_req_o && mem_gnt_i) issued_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q     <= req_vaddr_i;
          wr_q     <= req_write_i;
          usr_q    <= req_user_i;
          root_q   <= req_root_i;
          large_q  <= 1'b0;
          cause_q  <= CAUSE_NONE;
          issued_q <= 1'b0;
          state_q  <= ST_PDE;
        end
        ST_PDE: if (rd_done) begin
          issued_q    <= 1'b0;
          ent_q       <= mem_rdata_i;
          pde_frame_q <= mem_rdata_i[ADDR_W-1:OFF_W];
          pde_us_q    <= us_eff;
          pde_rw_q    <= rw_eff;
          if (chk_cause != CAUSE_NONE) begin
            cause_q <= chk_cause;
            state_q <= ST_FAULT;
          end else if (mem_rdata_i[FB_PS]) begin
            large_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_PTE;
          end
        end
        ST_PTE: if (rd_done) begin
          issued_q <= 1'b0;
          ent_q    <= mem_rdata_i;
          cause_q  <= chk_cause;
          state_q  <= (chk_cause != CAUSE_NONE) ? ST_FAULT : ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));
  a_r10_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r10_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
  a_r8_sup_no_prot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !usr_q |-> rsp_cause_o != CAUSE_PROT);
  a_r5_fault_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_fault_o == (rsp_cause_o != CAUSE_NONE));
  a_r4_large_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o && large_q |-> rsp_paddr_o[LG_OFF_W-1:0] == va_q[LG_OFF_W-1:0]);
  a_r3_small_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o && !large_q |-> rsp_paddr_o[OFF_W-1:0] == va_q[OFF_W-1:0]);
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [19:0] req_root = '0;
  logic        mem_req;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic [11:0] rsp_flags;

  always #10 clk = ~clk;  // 50 MHz

  ptw_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_user_i(req_user), .req_root_i(req_root),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause),
    .rsp_paddr_o(rsp_paddr), .rsp_flags_o(rsp_flags)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Behavioural memory: 16 KB, word index = addr[13:2]
  logic [31:0] mem [4096];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return (a[31:14] == 0) ? mem[a[13:2]] : 32'h0;
  endfunction

  // Memory responder, drives on falling edges
  int n_reads = 0, gnt_wait = 0, rsp_wait = 0, lat_sel = 0;
  bit rsp_pend = 1'b0;
  logic [31:0] gaddr = '0;
  logic [31:0] addr_hist [4];
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 1'b0; mem_rvalid = 1'b0; rsp_pend = 1'b0; gnt_wait = 0;
    end else begin
      mem_rvalid = 1'b0;
      if (mem_gnt) begin
        mem_gnt = 1'b0;
        rsp_pend = 1'b1;
        rsp_wait = lat_sel % 2;
        addr_hist[n_reads % 4] = gaddr;
        n_reads++;
      end else if (mem_req && !rsp_pend) begin
        if (gnt_wait == 0) begin
          mem_gnt = 1'b1;
          gaddr = mem_addr;
          lat_sel++;
          gnt_wait = lat_sel % 3;
        end else gnt_wait--;
      end
      if (rsp_pend) begin
        if (rsp_wait == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = rd(gaddr);
          rsp_pend = 1'b0;
        end else rsp_wait--;
      end
    end
  end

  // Reference walk from the requirements
  task automatic ref_walk(input logic [31:0] va, input bit wr, input bit usr,
                          input logic [19:0] root, output logic [1:0] cause,
                          output int reads, output logic [31:0] pa,
                          output logic [11:0] flg, output logic [31:0] a0,
                          output logic [31:0] a1);
    logic [31:0] pde, pte;
    a0 = {root, va[31:22], 2'b00};
    pde = rd(a0);
    reads = 1; pa = '0; flg = pde[11:0]; a1 = '0;
    if (!pde[0]) begin cause = 2'd1; return; end
    if (pde[7]) begin
      cause = (usr && (!pde[2] || (wr && !pde[1]))) ? 2'd2 : 2'd0;
      pa = {pde[31:22], va[21:0]};
      return;
    end
    if (usr && (!pde[2] || (wr && !pde[1]))) begin cause = 2'd2; return; end
    a1 = {pde[31:12], va[21:12], 2'b00};
    pte = rd(a1);
    reads = 2; flg = pte[11:0];
    if (!pte[0]) begin cause = 2'd1; return; end
    cause = (usr && (!(pde[2] & pte[2]) || (wr && !(pde[1] & pte[1])))) ? 2'd2 : 2'd0;
    pa = {pte[31:12], va[11:0]};
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic [19:0] root;
    logic [1:0]  cause;
    logic [1:0]  reads;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0123, 1'b1, 1'b1, 20'h0, 2'd0, 2'd2, 4'd3},   // R3 user write RW page
    '{32'h0000_1FFF, 1'b0, 1'b1, 20'h0, 2'd0, 2'd2, 4'd7},   // R7 user read of RO
    '{32'h0000_1004, 1'b1, 1'b1, 20'h0, 2'd2, 2'd2, 4'd7},   // R7 user write RO
    '{32'h0000_1004, 1'b1, 1'b0, 20'h0, 2'd0, 2'd2, 4'd8},   // R8 sup write RO
    '{32'h0000_2010, 1'b0, 1'b1, 20'h0, 2'd2, 2'd2, 4'd6},   // R6 user on sup page
    '{32'h0000_2010, 1'b1, 1'b0, 20'h0, 2'd0, 2'd2, 4'd8},   // R8
    '{32'h0000_3000, 1'b0, 1'b0, 20'h0, 2'd1, 2'd2, 4'd5},   // R5 table NP
    '{32'h0000_4800, 1'b1, 1'b1, 20'h0, 2'd0, 2'd2, 4'd11},  // R11 all flags set
    '{32'h0040_0456, 1'b1, 1'b1, 20'h0, 2'd2, 2'd1, 4'd9},   // R9 dir RO, early abort
    '{32'h0040_0456, 1'b0, 1'b1, 20'h0, 2'd0, 2'd2, 4'd7},   // R7
    '{32'h0040_0456, 1'b1, 1'b0, 20'h0, 2'd0, 2'd2, 4'd8},   // R8
    '{32'h0040_1000, 1'b0, 1'b1, 20'h0, 2'd2, 2'd2, 4'd6},   // R6 table-level sup
    '{32'h0080_0008, 1'b0, 1'b1, 20'h0, 2'd2, 2'd1, 4'd9},   // R9 dir sup
    '{32'h0080_0008, 1'b1, 1'b0, 20'h0, 2'd0, 2'd2, 4'd8},   // R8
    '{32'h00C0_0111, 1'b0, 1'b0, 20'h0, 2'd1, 2'd1, 4'd5},   // R5 dir NP
    '{32'h013F_FABC, 1'b1, 1'b1, 20'h0, 2'd0, 2'd1, 4'd4},   // R4 large
    '{32'h0141_2345, 1'b1, 1'b1, 20'h0, 2'd2, 2'd1, 4'd7},   // R7 large RO
    '{32'h0141_2345, 1'b1, 1'b0, 20'h0, 2'd0, 2'd1, 4'd8},   // R8 large RO sup
    '{32'h01A5_4321, 1'b0, 1'b1, 20'h0, 2'd2, 2'd1, 4'd6},   // R6 large sup
    '{32'h01A5_4321, 1'b1, 1'b0, 20'h0, 2'd0, 2'd1, 4'd4},   // R4
    '{32'h01C0_0040, 1'b0, 1'b0, 20'h0, 2'd1, 2'd1, 4'd5},   // R5 NP with bit 7
    '{32'h0000_0777, 1'b1, 1'b1, 20'h3, 2'd0, 2'd2, 4'd2}    // R2 other directory
  };

  task automatic start_req(input logic [31:0] va, input bit wr, input bit usr,
                           input logic [19:0] root);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; req_root = root;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    int snap, got_reads, e_reads, t;
    logic [1:0] e_cause;
    logic [31:0] e_pa, e_a0, e_a1;
    logic [11:0] e_flg;
    tag = $sformatf("R%0d", v.rq);
    ref_walk(v.va, v.wr, v.usr, v.root, e_cause, e_reads, e_pa, e_flg, e_a0, e_a1);
    snap = n_reads;
    start_req(v.va, v.wr, v.usr, v.root);
    chk(!req_ready, "R10", "ready while busy", {31'b0, req_ready}, 32'h0);
    t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    if (!rsp_valid) begin
      chk(1'b0, tag, "response timeout", 32'h0, 32'h1);
      return;
    end
    got_reads = n_reads - snap;
    chk(rsp_cause == v.cause && rsp_cause == e_cause, tag, "cause", {30'b0, rsp_cause}, {30'b0, v.cause});
    chk(rsp_fault == (v.cause != 0), tag, "fault", {31'b0, rsp_fault}, {31'b0, v.cause != 0});
    chk(got_reads == int'(v.reads) && got_reads == e_reads, tag, "read count", got_reads, e_reads);
    chk(addr_hist[snap % 4] == e_a0, "R2", "directory read addr", addr_hist[snap % 4], e_a0);
    if (e_reads == 2)
      chk(addr_hist[(snap + 1) % 4] == e_a1, "R2", "table read addr", addr_hist[(snap + 1) % 4], e_a1);
    chk(rsp_flags == e_flg, tag, "flags", {20'b0, rsp_flags}, {20'b0, e_flg});
    if (e_cause == 0) chk(rsp_paddr == e_pa, tag, "paddr", rsp_paddr, e_pa);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10", "pulse/idle", {30'b0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    // directory at 0x0000
    mem[0] = 32'h0000_1007;  mem[1] = 32'h0000_2005;  mem[2] = 32'h0000_1003;
    mem[3] = 32'hABCD_E006;  mem[4] = 32'h1240_00E7;  mem[5] = 32'h0800_0085;
    mem[6] = 32'h0C00_0083;  mem[7] = 32'h0000_0080;
    // table at 0x1000
    mem[1024] = 32'hAAAA_A007; mem[1025] = 32'hBBBB_B005; mem[1026] = 32'hCCCC_C003;
    mem[1027] = 32'hDDDD_D006; mem[1028] = 32'h1234_5FFF;
    // table at 0x2000
    mem[2048] = 32'h5555_5007; mem[2049] = 32'h6666_6003;
    // second directory at 0x3000
    mem[3072] = 32'h0000_2007;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_req, "R1", "reset outputs",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1", "idle after reset",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: reset in mid-walk returns to idle with no read pending
    start_req(32'h0000_0123, 1'b0, 1'b1, 20'h0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req && !rsp_valid, "R1", "reset mid-walk",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
    rst_n = 1'b1;
    run_vec(VECS[0]);
    run_vec(VECS[15]);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule